// File: doc/BRIEF.md
# ALU Result Two-Digit Seven-Segment Driver

This block turns the result of a small ALU into patterns for two seven-segment digits. It takes a mode flag, the ALU result word and the ALU carry-out. It drives two active-low segment buses, one for the upper digit and one for the lower digit. Both buses come from registers, so what they show follows the inputs by one clock.

When the mode flag marks a logic operation, the result word goes straight to the lower digit. Codes that are not decimal digits blank that digit, and the upper digit stays dark. When the flag marks an arithmetic operation, the carry and the result together form one unsigned value. A shift-and-add-3 converter turns that value into tens and units. The upper digit shows the tens, and it is blanked when the tens digit is zero.

Top module: `alu_seg_driver`

## Requirements
- R1: While `rst` is high at a rising clock edge, both segment buses become 1111111 (all segments off) in the following cycle.
- R2: The outputs are registered: each bus shows the inputs sampled at the previous rising edge and does not change between edges.
- R3: Segment buses are active-low with segment a in bit 6 and segment g in bit 0. Digit patterns: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R4: With `mode_arith`=0 and `result` from 0 to 9, `seg_lo` shows the pattern of `result`, and `carry` has no effect.
- R5: With `mode_arith`=0 and `result` from 10 to 15, `seg_lo` is 1111111.
- R6: With `mode_arith`=0, `seg_hi` is 1111111 for every `result` and `carry`.
- R7: With `mode_arith`=1, `seg_lo` shows the units digit of the value carry*16+result (0 to 31).
- R8: With `mode_arith`=1, `seg_hi` shows the tens digit of that value when it is 1 to 3, and is 1111111 when the value is below 10.
- R9: With `mode_arith`=1 and the value equal to zero, `seg_lo` shows 0 (0000001) and is not blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_arith | input | 1 | 0 = logic result, 1 = arithmetic result |
| result | input | 4 | ALU result word |
| carry | input | 1 | ALU carry-out, used in arithmetic mode |
| seg_hi | output | 7 | Upper digit segments a..g, active-low |
| seg_lo | output | 7 | Lower digit segments a..g, active-low |

## Verification
The bench applies every combination of mode, carry and result (64 cases) and compares both buses with a behavioural model built from integer division by ten and the digit table.

- The logic-mode sweep with carry high and with carry low shows that carry is ignored.
- The codes 10 to 15 separate the blanking path from the digit table.
- In arithmetic mode, the values 0, 9, 10, 16 and 31 separate leading-zero suppression, the case of exactly zero, and the decimal corrections that the conversion applies.

A step from a reset state to the value 31 shows the one-cycle latency, and a reset late in the run shows that both digits return to blank.

// File: rtl/alu_seg_pkg.sv
package alu_seg_pkg;

  localparam int SEG_W = 7;
  localparam logic [SEG_W-1:0] SEG_OFF = 7'b1111111;

  // active-low pattern, bit 6 = segment a ... bit 0 = segment g
  function automatic logic [SEG_W-1:0] digit_to_seg(input logic [3:0] code);
    logic [SEG_W-1:0] s;
    case (code)
      4'd0: s = 7'b0000001;
      4'd1: s = 7'b1001111;
      4'd2: s = 7'b0010010;
      4'd3: s = 7'b0000110;
      4'd4: s = 7'b1001100;
      4'd5: s = 7'b0100100;
      4'd6: s = 7'b0100000;
      4'd7: s = 7'b0001111;
      4'd8: s = 7'b0000000;
      4'd9: s = 7'b0000100;
      default: s = SEG_OFF;
    endcase
    return s;
  endfunction

  // number of decimal digits needed for an unsigned value of w bits
  function automatic int dec_digits(input int w);
    longint m;
    int n;
    m = (longint'(1) << w) - 1;
    n = 1;
    while (m >= 10) begin
      m = m / 10;
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/bin_to_bcd.sv
module bin_to_bcd #(
  parameter int IN_W = 5,
  parameter int DIG  = 2
) (
  input  logic [IN_W-1:0]  bin,
  output logic [DIG*4-1:0] bcd
);
  localparam int BW = DIG * 4;

  always_comb begin
    logic [BW-1:0] acc;
    acc = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      for (int d = 0; d < DIG; d++) begin
        if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[BW-2:0], bin[i]};
    end
    bcd = acc;
  end
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
  import alu_seg_pkg::*;
(
  input  logic [3:0]       code,
  input  logic             blank,
  output logic [SEG_W-1:0] seg
);
  always_comb begin
    if (blank) seg = SEG_OFF;
    else       seg = digit_to_seg(code);
  end
endmodule

// File: rtl/alu_seg_driver.sv
module alu_seg_driver
  import alu_seg_pkg::*;
#(
  parameter int RES_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_arith,
  input  logic [RES_W-1:0] result,
  input  logic             carry,
  output logic [6:0]       seg_hi,
  output logic [6:0]       seg_lo
);
  localparam int VAL_W  = RES_W + 1;
  localparam int DIG    = dec_digits(VAL_W);
  localparam int NDISP  = 2;

  logic [VAL_W-1:0] value;
  logic [DIG*4-1:0] bcd;
  logic [3:0]       code  [NDISP];
  logic             blank [NDISP];
  logic [SEG_W-1:0] seg_n [NDISP];

  assign value = {carry, result};

  bin_to_bcd #(.IN_W(VAL_W), .DIG(DIG)) u_bcd (
    .bin (value),
    .bcd (bcd)
  );

  // digit 0 = lower display, digit 1 = upper display
  always_comb begin
    if (mode_arith) begin
      code[0]  = bcd[3:0];
      blank[0] = 1'b0;
      code[1]  = bcd[7:4];
      blank[1] = (bcd[7:4] == 4'd0);
    end else begin
      code[0]  = result[3:0];
      blank[0] = 1'b0;
      code[1]  = 4'd0;
      blank[1] = 1'b1;
    end
  end

  for (genvar g = 0; g < NDISP; g++) begin : g_disp
    seg_encoder u_enc (
      .code  (code[g]),
      .blank (blank[g]),
      .seg   (seg_n[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_lo <= SEG_OFF;
      seg_hi <= SEG_OFF;
    end else begin
      seg_lo <= seg_n[0];
      seg_hi <= seg_n[1];
    end
  end
endmodule

// File: rtl/alu_seg_driver_chk.sv
module alu_seg_driver_chk #(
  parameter int RES_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_arith,
  input logic [RES_W-1:0] result,
  input logic             carry,
  input logic [6:0]       seg_hi,
  input logic [6:0]       seg_lo
);
  logic [RES_W:0] val;
  assign val = {carry, result};

  p_reset_blank_r1: assert property (@(posedge clk)
    rst |=> (seg_hi == 7'b1111111 && seg_lo == 7'b1111111));

  p_logic_hi_dark_r6: assert property (@(posedge clk) disable iff (rst)
    !mode_arith |=> seg_hi == 7'b1111111);

  p_logic_bad_code_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode_arith && result > 9) |=> seg_lo == 7'b1111111);

  p_arith_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_arith && val == 0) |=> seg_lo == 7'b0000001);

  p_arith_lead_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_arith && val < 10) |=> seg_hi == 7'b1111111);

  p_arith_tens_lit_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_arith && val >= 10) |=> seg_hi != 7'b1111111);

  p_arith_units_lit_r7: assert property (@(posedge clk) disable iff (rst)
    mode_arith |=> seg_lo != 7'b1111111);
endmodule

bind alu_seg_driver alu_seg_driver_chk #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_arith (mode_arith),
  .result     (result),
  .carry      (carry),
  .seg_hi     (seg_hi),
  .seg_lo     (seg_lo)
);

// File: tb/sim_alu_seg_driver.sv
module sim_alu_seg_driver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_arith = 1'b0;
  logic [3:0] result = 4'd0;
  logic       carry = 1'b0;
  logic [6:0] seg_hi, seg_lo;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  alu_seg_driver u0 (
    .clk        (clk),
    .rst        (rst),
    .mode_arith (mode_arith),
    .result     (result),
    .carry      (carry),
    .seg_hi     (seg_hi),
    .seg_lo     (seg_lo)
  );

  localparam logic [6:0] OFF = 7'b1111111;

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'b0000001;
      1: return 7'b1001111;
      2: return 7'b0010010;
      3: return 7'b0000110;
      4: return 7'b1001100;
      5: return 7'b0100100;
      6: return 7'b0100000;
      7: return 7'b0001111;
      8: return 7'b0000000;
      9: return 7'b0000100;
      default: return OFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // reset with an arithmetic value of 31 waiting on the inputs
    mode_arith = 1'b1; carry = 1'b1; result = 4'd15;
    repeat (3) @(negedge clk);
    chk("R1 reset seg_hi", seg_hi, OFF);
    chk("R1 reset seg_lo", seg_lo, OFF);
    rst = 1'b0;
    #1;
    chk("R2 no change before edge", seg_hi, OFF);
    @(negedge clk);
    chk("R2/R8 after one edge seg_hi", seg_hi, pat(3));
    chk("R2/R7 after one edge seg_lo", seg_lo, pat(1));

    // full sweep of mode, carry and result
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < 16; r++) begin
          int v;
          logic [6:0] e_hi, e_lo;
          string t_hi, t_lo;
          mode_arith = m[0]; carry = c[0]; result = r[3:0];
          v = c * 16 + r;
          if (m == 0) begin
            e_hi = OFF; t_hi = "R6";
            e_lo = pat(r);
            t_lo = (r <= 9) ? "R4/R3" : "R5";
          end else begin
            e_hi = (v / 10 == 0) ? OFF : pat(v / 10); t_hi = "R8/R3";
            e_lo = pat(v % 10);
            t_lo = (v == 0) ? "R9" : "R7/R3";
          end
          @(negedge clk);
          chk($sformatf("%s seg_hi m=%0d c=%0d r=%0d", t_hi, m, c, r), seg_hi, e_hi);
          chk($sformatf("%s seg_lo m=%0d c=%0d r=%0d", t_lo, m, c, r), seg_lo, e_lo);
        end
      end
    end

    // reset late in the run
    rst = 1'b1;
    @(negedge clk);
    chk("R1 late reset seg_hi", seg_hi, OFF);
    chk("R1 late reset seg_lo", seg_lo, OFF);
    rst = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule